// File: doc/BRIEF.md
# Cell Channel Selector Control

This block is the digital controller in front of a sixteen-way analog selector serving a stack of fourteen series cells plus two auxiliary inputs. It turns host commands into a one-hot switch-enable vector, a force-current control bit and a flag that says when the selected analog path has had time to settle. The analog switches, level shifting and supply generation sit outside the block.

There are two ways to choose a source. The first is a five-bit frame sent over a serial link (clock, active-low select, data in, data out). The frame passes through a shift chain and is copied into a store register when the select line is released. The second is a set of four direct address pins. These take over whenever they hold anything other than all ones. In that mode the serial link is ignored and the auxiliary codes cannot be reached.

All serial and pin inputs are asynchronous to the system clock. They are brought in through synchronizers, and every edge is detected in the system clock domain. A programmable count of system clocks stands in for the analog settling time.

Top module: `cell_mux_ctrl`

## Requirements
- R1: A frame is armed only when the select line falls while the serial clock is high. If the select line falls while the clock is low, no bit is shifted and the release that follows commits nothing.
- R2: In an armed frame, one data bit is captured on each rising serial clock. Bits arrive address MSB first, then the lower address bits, and the last bit of a five-bit frame is the force-current bit. The stored word is {addr[3:0], force}.
- R3: Serial data out is updated on falling serial clock edges from the fourth stage of the chain, so the first bit of a frame appears on it at the fifth falling edge of that frame.
- R4: The serial output enable is low whenever the select line is high and high while it is low (serial mode).
- R5: Releasing an armed select line copies the shift chain into the store register. Only the last five bits shifted in count. A shorter frame commits the older chain bits shifted up by the number of new bits.
- R6: Address code k in 0..13 drives select bit k (cells from the bottom up). Code 14 drives bit 14 (auxiliary 1) and code 15 drives bit 15 (auxiliary 2). At most one select bit is ever high.
- R7: When the direct pins hold any value other than 4'b1111, that value selects the channel, and a serial frame sent meanwhile leaves the store register unchanged. Direct code 4'b1110 gives no selection (all zeros, valid low). When the pins return to 4'b1111, the stored serial address applies again.
- R8: The force-current output equals the force bit of the store register, in both modes and for every address.
- R9: Driving the register reset low clears the shift chain and the store register. After release the selection is code 0 (bit 0) with the force bit at 0.
- R10: Any change of the selection drops the valid flag. The flag rises again once SETTLE_CYCLES system clocks have passed with no further change.
- R11: While shutdown is low, the select vector is all zeros and the valid flag is low. When shutdown is released the settle count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sck | input | 1 | Serial clock (asynchronous) |
| cs_n | input | 1 | Serial select, active low |
| mosi | input | 1 | Serial data in |
| rreg_n | input | 1 | Register reset, active low, asynchronous |
| sd_n | input | 1 | Shutdown, active low |
| dsel | input | 4 | Direct address pins; 4'b1111 hands control to the serial path |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for serial data out |
| sel | output | 16 | One-hot source select |
| force_cur | output | 1 | Stored force-current bit |
| sel_valid | output | 1 | Selection settled |

## Verification
Every input passes through SYNC_STAGES (2) flops and an edge register. A serial edge therefore reaches the chain or the store register on the third system clock after it is driven, and the select vector follows one clock later. A direct pin change reaches the select vector on the third clock. The valid flag rises SETTLE_CYCLES clocks after the select vector changes. The bench holds each serial clock phase for four system clocks and checks selections eight clocks after a commit or pin change. It checks the valid flag once shortly after a change, when it must be low, and again SETTLE_CYCLES plus a margin later, when it must be high.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned NSRC    = 1 << ADDR_W;
  localparam int unsigned FRAME_W = ADDR_W + 1;

  typedef logic [ADDR_W-1:0]  code_t;
  typedef logic [NSRC-1:0]    onehot_t;
  typedef logic [FRAME_W-1:0] frame_t;

  // one-hot decode of a source code
  function automatic onehot_t code_to_onehot(input code_t c);
    onehot_t v;
    v = '0;
    v[c] = 1'b1;
    return v;
  endfunction

  // direct pins take over unless every pin is high
  function automatic logic pins_direct(input code_t p);
    return p != '1;
  endfunction

  // address field of a stored frame
  function automatic code_t frame_code(input frame_t f);
    return f[FRAME_W-1:1];
  endfunction
endpackage

// File: rtl/cmx_sync.sv
module cmx_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cmx_serial.sv
module cmx_serial
  import cmx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sck_s,
  input  logic   cs_s,
  input  logic   mosi_s,
  input  logic   serial_en,
  output frame_t chain,
  output frame_t store,
  output logic   commit_evt,
  output logic   miso,
  output logic   miso_oe
);
  logic p_sck, p_cs, armed;
  logic sck_rise, sck_fall, cs_fall, cs_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_sck <= 1'b0;
      p_cs  <= 1'b1;
    end else begin
      p_sck <= sck_s;
      p_cs  <= cs_s;
    end
  end

  assign sck_rise = sck_s & ~p_sck;
  assign sck_fall = ~sck_s & p_sck;
  assign cs_fall  = ~cs_s & p_cs;
  assign cs_rise  = cs_s & ~p_cs;

  assign commit_evt = cs_rise & armed & serial_en;

  // arming: select must fall while the serial clock is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              armed <= 1'b0;
    else if (cs_rise || !serial_en)          armed <= 1'b0;
    else if (cs_fall && sck_s)               armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      store <= '0;
      miso  <= 1'b0;
    end else begin
      if (armed && serial_en && !cs_s && sck_rise)
        chain <= {chain[FRAME_W-2:0], mosi_s};
      if (armed && serial_en && !cs_s && sck_fall)
        miso <= chain[FRAME_W-2];
      if (commit_evt)
        store <= chain;
    end
  end

  assign miso_oe = ~cs_s & serial_en;
endmodule

// File: rtl/cmx_select.sv
module cmx_select
  import cmx_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 100
) (
  input  logic    clk,
  input  logic    rst_n,
  input  code_t   eff_code,
  input  logic    code_ok,
  input  logic    sd_s,
  output onehot_t sel,
  output logic    sel_valid
);
  localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(SETTLE_CYCLES);

  code_t         cur_code;
  logic          cur_ok;
  logic [CW-1:0] cnt;
  logic          change;

  assign change = (eff_code != cur_code) || (code_ok != cur_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_code <= '0;
      cur_ok   <= 1'b1;
      cnt      <= RELOAD;
    end else begin
      cur_code <= eff_code;
      cur_ok   <= code_ok;
      if (change || !sd_s)  cnt <= RELOAD;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
    end
  end

  assign sel       = (sd_s && cur_ok) ? code_to_onehot(cur_code) : '0;
  assign sel_valid = sd_s && cur_ok && (cnt == '0);
endmodule

// File: rtl/cell_mux_ctrl.sv
module cell_mux_ctrl
  import cmx_pkg::*;
#(
  parameter int unsigned NCELL         = 14,
  parameter int unsigned SETTLE_CYCLES = 100,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic              rreg_n,
  input  logic              sd_n,
  input  logic [ADDR_W-1:0] dsel,
  output logic              miso,
  output logic              miso_oe,
  output logic [NSRC-1:0]   sel,
  output logic              force_cur,
  output logic              sel_valid
);
  localparam int unsigned SW = ADDR_W + 4;
  localparam logic [SW-1:0] SYNC_RST = {{ADDR_W{1'b1}}, 4'b0010};

  logic [SW-1:0] raw_in, syn;
  code_t         dir_s;
  logic          sd_s, mosi_s, cs_s, sck_s;
  logic          dir_mode, code_ok, commit_evt;
  code_t         eff_code;
  frame_t        chain, store;

  assign raw_in = {dsel, sd_n, mosi, cs_n, sck};

  cmx_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rreg_n), .d(raw_in), .q(syn)
  );

  assign {dir_s, sd_s, mosi_s, cs_s, sck_s} = syn;
  assign dir_mode = pins_direct(dir_s);

  cmx_serial u_ser (
    .clk(clk), .rst_n(rreg_n), .sck_s(sck_s), .cs_s(cs_s), .mosi_s(mosi_s),
    .serial_en(~dir_mode), .chain(chain), .store(store),
    .commit_evt(commit_evt), .miso(miso), .miso_oe(miso_oe)
  );

  assign eff_code = dir_mode ? dir_s : frame_code(store);
  assign code_ok  = !dir_mode || (32'(dir_s) < NCELL);

  cmx_select #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_selc (
    .clk(clk), .rst_n(rreg_n), .eff_code(eff_code), .code_ok(code_ok),
    .sd_s(sd_s), .sel(sel), .sel_valid(sel_valid)
  );

  assign force_cur = store[0];
endmodule

// File: rtl/cmx_chk.sv
module cmx_chk
  import cmx_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input onehot_t   sel,
  input logic      sel_valid,
  input logic      sd_s,
  input logic      dir_mode,
  input code_t     dir_s,
  input logic      commit_evt,
  input frame_t    chain,
  input frame_t    store
);
  // R6
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> ($countones(sel) == 1));

  // R11
  shutdown_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_s |-> (sel == '0 && !sel_valid));

  // R5
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (store == $past(chain)));

  // R7
  direct_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_s && dir_mode && dir_s != 4'hE) |=> (!sd_s || sel[$past(dir_s)]));

  // R10
  change_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_s && $past(sd_s) && sel != $past(sel)) |-> !sel_valid);
endmodule

bind cell_mux_ctrl cmx_chk u_chk (
  .clk(clk), .rst_n(rreg_n), .sel(sel), .sel_valid(sel_valid), .sd_s(sd_s),
  .dir_mode(dir_mode), .dir_s(dir_s), .commit_evt(commit_evt),
  .chain(chain), .store(store)
);

// File: tb/sim_cell_mux_ctrl.sv
module sim_cell_mux_ctrl;
  localparam int CLK_P  = 10;
  localparam int SETTLE = 20;
  localparam int HALF   = 4;

  logic clk = 0, sck = 1, cs_n = 1, mosi = 0, rreg_n = 0, sd_n = 1;
  logic [3:0] dsel = 4'hF;
  logic miso, miso_oe, force_cur, sel_valid;
  logic [15:0] sel;

  int errs = 0, checks = 0;
  logic [4:0] m_sh = 0, m_store = 0;

  always #(CLK_P/2) clk = ~clk;

  cell_mux_ctrl #(.SETTLE_CYCLES(SETTLE)) u0 (
    .clk(clk), .sck(sck), .cs_n(cs_n), .mosi(mosi), .rreg_n(rreg_n),
    .sd_n(sd_n), .dsel(dsel), .miso(miso), .miso_oe(miso_oe), .sel(sel),
    .force_cur(force_cur), .sel_valid(sel_valid)
  );

  // {dir[15:12], -, word[10:6], exp idx[5:1] (16 = none), exp force[0]}
  localparam logic [15:0] VEC [10] = '{
    {4'hF, 1'b0, 5'b00110, 5'd3,  1'b0},
    {4'hF, 1'b0, 5'b11011, 5'd13, 1'b1},
    {4'hF, 1'b0, 5'b11100, 5'd14, 1'b0},
    {4'hF, 1'b0, 5'b11111, 5'd15, 1'b1},
    {4'h5, 1'b0, 5'b00000, 5'd5,  1'b1},
    {4'h0, 1'b0, 5'b00000, 5'd0,  1'b1},
    {4'hD, 1'b0, 5'b00000, 5'd13, 1'b1},
    {4'hF, 1'b0, 5'b01100, 5'd6,  1'b0},
    {4'hE, 1'b0, 5'b00000, 5'd16, 1'b0},
    {4'hF, 1'b0, 5'b10010, 5'd9,  1'b0}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] idx_vec(input int idx);
    return (idx >= 16) ? 16'h0 : (16'h1 << idx);
  endfunction

  task automatic frame(input logic [15:0] bits, input int n, input bit arm_hi,
                       input bit take, input bit chk_sdo);
    if (!arm_hi) begin sck = 0; tick(HALF); end
    cs_n = 0;
    tick(HALF);
    if (chk_sdo) check("R4 oe low-select", miso_oe, 1);
    for (int i = 0; i < n; i++) begin
      sck = 0;
      mosi = bits[n-1-i];
      tick(HALF);
      if (chk_sdo && i == 4) check("R3 first bit at 5th fall", miso, bits[n-1]);
      sck = 1;
      if (arm_hi && take) m_sh = {m_sh[3:0], bits[n-1-i]};
      tick(HALF);
    end
    cs_n = 1;
    tick(HALF);
    if (chk_sdo) check("R4 oe high-select", miso_oe, 0);
    if (arm_hi && take) m_store = m_sh;
  endtask

  initial begin : watchdog
    #(CLK_P * 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    tick(5);
    rreg_n = 1;
    tick(6);
    // R9 reset state
    check("R9 reset sel", sel, 16'h1);
    check("R9 reset force", force_cur, 0);
    check("R10 valid low after reset", sel_valid, 0);
    check("R4 oe idle", miso_oe, 0);
    tick(SETTLE + 4);
    check("R10 valid after settle", sel_valid, 1);

    // table walk: R2 R6 R7 R8 R10
    for (int r = 0; r < 10; r++) begin
      logic [3:0] d;
      d = VEC[r][15:12];
      if (d == 4'hF) begin
        dsel = 4'hF;
        tick(6);
        frame({11'h0, VEC[r][10:6]}, 5, 1, 1, 1);
        tick(4);
      end else begin
        dsel = d;
        tick(8);
      end
      check("R6/R7 table sel", sel, idx_vec(int'(VEC[r][5:1])));
      check("R8 table force", force_cur, VEC[r][0]);
      if (VEC[r][5:1] != 5'd16) check("R10 valid low after change", sel_valid, 0);
      tick(SETTLE + 6);
      check("R10 table valid", sel_valid, (VEC[r][5:1] != 5'd16));
    end

    // R5 short frame: 3 bits mix with older chain contents
    frame(16'b101, 3, 1, 1, 0);
    tick(4);
    check("R5 short frame sel", sel, idx_vec(int'(m_store[4:1])));
    check("R5 short frame force", force_cur, m_store[0]);
    // R5 long frame: only last five count
    frame(16'b1100101, 7, 1, 1, 1);
    tick(4);
    check("R5 long frame sel", sel, idx_vec(2));
    check("R5 long frame force", force_cur, 1);

    // R1 select falls while clock low: ignored
    frame(16'b01110, 5, 0, 0, 0);
    tick(4);
    check("R1 unarmed frame sel", sel, idx_vec(2));
    check("R1 unarmed frame force", force_cur, 1);

    // R7 serial ignored in direct mode
    dsel = 4'h4;
    tick(6);
    frame(16'b11000, 5, 1, 0, 0);
    dsel = 4'hF;
    tick(8);
    check("R7 serial ignored sel", sel, idx_vec(2));

    // R11 shutdown
    tick(SETTLE + 4);
    sd_n = 0;
    tick(6);
    check("R11 shutdown sel", sel, 16'h0);
    check("R11 shutdown valid", sel_valid, 0);
    sd_n = 1;
    tick(6);
    check("R11 wake sel", sel, idx_vec(2));
    check("R11 wake valid low", sel_valid, 0);
    tick(SETTLE + 4);
    check("R11 wake valid", sel_valid, 1);

    // R9 reset mid-run
    rreg_n = 0;
    tick(3);
    rreg_n = 1;
    m_sh = 0; m_store = 0;
    tick(6);
    check("R9 reset clears sel", sel, 16'h1);
    check("R9 reset clears force", force_cur, 0);
    // short frame after reset exposes cleared chain
    frame(16'b11, 2, 1, 1, 0);
    tick(4);
    check("R9 chain cleared", sel, idx_vec(int'(m_store[4:1])));
    check("R2 last bit is force", force_cur, m_store[0]);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule